// File: doc/BRIEF.md
# SDRAM Power-Up Initialisation and Refresh Sequencer

This block is the front end of a memory controller for a 32-bit-wide SDRAM array. Once reset is released it keeps the command bus idle for a power-on settling period. It then issues precharge-all with a mode-register write directly behind it, a block of auto-refresh commands and a second mode-register write without a precharge. Each of these command groups is followed by an idle gap. The block then runs a fixed number of dummy accesses to let the devices settle, and only after those does it raise `ready`.

The periodic refresh timer starts on the first dummy-access cycle. A prescaler divides the clock by 8 or by 16, and the timer expires after a fixed number of prescaler ticks. Each expiry requests a burst of four auto-refresh commands. The reported memory size selects the divider: arrays of 32 MB or less are refreshed at half the rate. A refresh request that arrives during a dummy access is held until that access ends, and it is then served before the next access starts.

Top module: `sdram_init_seq`

## Requirements
- R1: From reset release the command bus carries NOP (code 2'b00) for PWRUP_CYC cycles (default 10000, 200 us at 50 MHz). While reset is held, `cmd` is NOP and `ready` and `dummy_busy` are 0.
- R2: The command codes are NOP=2'b00, precharge-all=2'b01, auto-refresh=2'b10 and mode-set=2'b11. After the power-up wait the order is: precharge-all for one cycle, then mode-set in the next cycle, then GAP_CYC NOPs, then INIT_LOOPS×REF_GROUP (8) auto-refreshes, one every REF_SLOT cycles with NOPs between them, then GAP_CYC NOPs, then one mode-set with no precharge before it, then GAP_CYC NOPs.
- R3: During a mode-set cycle `mode_addr` carries the mode value 0x22 shifted left by two (0x088). This value means CAS latency 2, sequential bursts of 4 and burst writes. The two lowest address lines are unused on a 32-bit array. In all other cycles `mode_addr` is 0.
- R4: After the last gap, DUMMY_COUNT (10) dummy accesses of DUMMY_CYC cycles each follow. `dummy_busy` is high throughout every access, and `cmd` is NOP while it is high.
- R5: `ready` rises in the cycle after the last dummy access ends and stays high until the next reset.
- R6: No refresh request exists before the timer is enabled. The timer is enabled in the first dummy-access cycle.
- R7: The timer expires every PERIOD_TICKS×div cycles, where PERIOD_TICKS defaults to 195. The cycles are counted from the first dummy-access cycle, and each expiry is visible in the cycle it lands on. When the sequencer is idle, the following cycle starts a burst of REF_GROUP (4) auto-refreshes, one every REF_SLOT cycles.
- R8: A request that is pending while a dummy access runs starts its burst in the cycle after that access ends. The remaining dummy accesses resume right after the burst.
- R9: When `mem_size_mb` is at most 32, div is 16 and `refresh_slow` is 1. Otherwise div is 8 and `refresh_slow` is 0. For example, 32 selects the slow rate and 33 the fast rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_size_mb | input | SIZE_W | Detected array size in megabytes; selects the refresh rate |
| cmd | output | 2 | SDRAM command code |
| mode_addr | output | ADDR_W | Address bus value during mode-set |
| dummy_busy | output | 1 | A settling dummy access is in progress |
| ready | output | 1 | Initialisation complete |
| refresh_slow | output | 1 | Half-rate refresh divider selected |

## Verification
The assertions assume that a refresh burst is shorter than one timer period, so that at most one request is ever outstanding. They also assume that `mem_size_mb` does not change while the timer is counting. The stimulus therefore chooses burst and period lengths that keep a burst well inside a period. It changes the size only while reset is held, covering a size above the threshold, the threshold itself and the value one above it. One run places an expiry inside a dummy access so that the hold-off path is exercised. Another lets the first expiry land after `ready`, so that the burst starts from idle.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int PWRUP_CYC    = 10000,
  parameter int GAP_CYC      = 100,
  parameter int REF_SLOT     = 4,
  parameter int REF_GROUP    = 4,
  parameter int INIT_LOOPS   = 2,
  parameter int PERIOD_TICKS = 195,
  parameter int FAST_DIV     = 8,
  parameter int SLOW_DIV     = 16,
  parameter int DUMMY_COUNT  = 10,
  parameter int DUMMY_CYC    = 4,
  parameter int SIZE_W       = 16,
  parameter int SMALL_MB     = 32,
  parameter int ADDR_W       = 13,
  parameter int MODE_VAL     = 'h22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] mem_size_mb,
  output logic [1:0]        cmd,
  output logic [ADDR_W-1:0] mode_addr,
  output logic              dummy_busy,
  output logic              ready,
  output logic              refresh_slow
);

  localparam int INIT_REFS = INIT_LOOPS * REF_GROUP;
  localparam int CNT_MAX   = (PWRUP_CYC > GAP_CYC) ?
                             ((PWRUP_CYC > DUMMY_CYC) ? PWRUP_CYC : DUMMY_CYC) :
                             ((GAP_CYC > DUMMY_CYC) ? GAP_CYC : DUMMY_CYC);
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int SL_W      = $clog2(REF_SLOT);
  localparam int NR_W      = $clog2((INIT_REFS > REF_GROUP) ? INIT_REFS : REF_GROUP);
  localparam int DC_W      = $clog2(DUMMY_COUNT + 1);
  localparam int PRE_W     = $clog2((SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV);
  localparam int PER_W     = $clog2(PERIOD_TICKS);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(MODE_VAL) << 2;

  localparam logic [1:0] C_NOP = 2'b00;
  localparam logic [1:0] C_PRE = 2'b01;
  localparam logic [1:0] C_REF = 2'b10;
  localparam logic [1:0] C_MRS = 2'b11;

  typedef enum logic [3:0] {
    S_PWR, S_PRE, S_MRS_A, S_GAP_A, S_IREF, S_GAP_B,
    S_MRS_B, S_GAP_C, S_DUM, S_IDLE, S_RREF
  } st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [SL_W-1:0]  slot;
  logic [NR_W-1:0]  nref;
  logic [DC_W-1:0]  dcnt;
  logic             ref_en;
  logic             pend;
  logic [PRE_W-1:0] pre_cnt;
  logic [PER_W-1:0] per_cnt;

  logic             gap_done, slot_last, acc_end, last_acc;
  logic             tick, expire, take;
  logic [PRE_W-1:0] div_m1;

  assign gap_done     = cnt == CNT_W'(GAP_CYC - 1);
  assign slot_last    = slot == SL_W'(REF_SLOT - 1);
  assign acc_end      = cnt == CNT_W'(DUMMY_CYC - 1);
  assign last_acc     = dcnt == DC_W'(DUMMY_COUNT - 1);
  assign refresh_slow = mem_size_mb <= SIZE_W'(SMALL_MB);
  assign div_m1       = refresh_slow ? PRE_W'(SLOW_DIV - 1) : PRE_W'(FAST_DIV - 1);
  assign tick         = ref_en && (pre_cnt >= div_m1);
  assign expire       = tick && (per_cnt == PER_W'(PERIOD_TICKS - 1));
  assign take         = pend && ((st == S_IDLE) || (st == S_DUM && acc_end));
  assign dummy_busy   = st == S_DUM;
  assign mode_addr    = (st == S_MRS_A || st == S_MRS_B) ? MODE_ADDR : '0;

  always_comb begin
    case (st)
      S_PRE:           cmd = C_PRE;
      S_MRS_A, S_MRS_B: cmd = C_MRS;
      S_IREF, S_RREF:  cmd = (slot == '0) ? C_REF : C_NOP;
      default:         cmd = C_NOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_PWR;
      cnt   <= '0;
      slot  <= '0;
      nref  <= '0;
      dcnt  <= '0;
      ready <= 1'b0;
      ref_en <= 1'b0;
    end else begin
      case (st)
        S_PWR:
          if (cnt == CNT_W'(PWRUP_CYC - 1)) begin
            st  <= S_PRE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        S_PRE: st <= S_MRS_A;
        S_MRS_A: begin
          st  <= S_GAP_A;
          cnt <= '0;
        end
        S_GAP_A:
          if (gap_done) begin
            st   <= S_IREF;
            slot <= '0;
            nref <= '0;
          end else cnt <= cnt + 1'b1;
        S_IREF:
          if (slot_last) begin
            slot <= '0;
            if (nref == NR_W'(INIT_REFS - 1)) begin
              st  <= S_GAP_B;
              cnt <= '0;
            end else nref <= nref + 1'b1;
          end else slot <= slot + 1'b1;
        S_GAP_B:
          if (gap_done) st <= S_MRS_B;
          else cnt <= cnt + 1'b1;
        S_MRS_B: begin
          st  <= S_GAP_C;
          cnt <= '0;
        end
        S_GAP_C:
          if (gap_done) begin
            st     <= S_DUM;
            cnt    <= '0;
            dcnt   <= '0;
            ref_en <= 1'b1;
          end else cnt <= cnt + 1'b1;
        S_DUM:
          if (acc_end) begin
            cnt  <= '0;
            dcnt <= dcnt + 1'b1;
            if (last_acc) ready <= 1'b1;
            if (pend) begin
              st   <= S_RREF;
              slot <= '0;
              nref <= '0;
            end else if (last_acc) st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        S_IDLE:
          if (pend) begin
            st   <= S_RREF;
            slot <= '0;
            nref <= '0;
          end
        S_RREF:
          if (slot_last) begin
            slot <= '0;
            if (nref == NR_W'(REF_GROUP - 1)) begin
              cnt <= '0;
              st  <= (dcnt != DC_W'(DUMMY_COUNT)) ? S_DUM : S_IDLE;
            end else nref <= nref + 1'b1;
          end else slot <= slot + 1'b1;
        default: st <= S_PWR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      per_cnt <= '0;
      pend    <= 1'b0;
    end else begin
      if (tick) begin
        pre_cnt <= '0;
        per_cnt <= expire ? '0 : per_cnt + 1'b1;
      end else if (ref_en) pre_cnt <= pre_cnt + 1'b1;
      if (expire) pend <= 1'b1;
      else if (take) pend <= 1'b0;
    end
  end

  logic [CNT_W-1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != CNT_W'(PWRUP_CYC)) up_cnt <= up_cnt + 1'b1;
  end

  assert_pwrup_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt < CNT_W'(PWRUP_CYC)) |-> cmd == C_NOP);

  assert_pre_then_mrs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == C_PRE |=> cmd == C_MRS);

  assert_mrs_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == C_MRS |-> mode_addr == MODE_ADDR);

  assert_dummy_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_busy |-> cmd == C_NOP);

  assert_ready_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  assert_ready_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(dummy_busy));

  assert_pend_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> ref_en);

  assert_holdoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dummy_busy && pend && acc_end) |=> cmd == C_REF);

endmodule

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;
  localparam int P = 40, G = 5, S = 3, GRP = 4, LOOPS = 2, PER = 3;
  localparam int FD = 8, SD = 16, DCNT = 10, DC = 4, SMALL = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] size_mb = 16'd64;
  logic [1:0]  cmd;
  logic [12:0] mode_addr;
  logic        dummy_busy, ready, refresh_slow;

  always #2.5 clk = ~clk;

  sdram_init_seq #(
    .PWRUP_CYC(P), .GAP_CYC(G), .REF_SLOT(S), .REF_GROUP(GRP), .INIT_LOOPS(LOOPS),
    .PERIOD_TICKS(PER), .FAST_DIV(FD), .SLOW_DIV(SD), .DUMMY_COUNT(DCNT),
    .DUMMY_CYC(DC), .SIZE_W(16), .SMALL_MB(SMALL), .ADDR_W(13), .MODE_VAL('h22)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_size_mb(size_mb), .cmd(cmd), .mode_addr(mode_addr),
    .dummy_busy(dummy_busy), .ready(ready), .refresh_slow(refresh_slow)
  );

  int checks = 0, errors = 0;
  int q[$];
  int ph, idx, sub, dn, cyc, t0, tper, pend_m, en_m, rdy_m;
  int init_refs, run_refs, hold_refs, exp_run_refs, holdoff_bursts;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int exp_cmd();
    case (ph)
      0: return q[idx];
      3: return (sub % S == 0) ? 2 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    q.delete();
    repeat (P) q.push_back(0);
    q.push_back(1);
    q.push_back(3);
    repeat (G) q.push_back(0);
    for (int r = 0; r < LOOPS * GRP; r++) begin
      q.push_back(2);
      repeat (S - 1) q.push_back(0);
    end
    repeat (G) q.push_back(0);
    q.push_back(3);
    repeat (G) q.push_back(0);
    tper = PER * ((size_mb <= SMALL) ? SD : FD);
    ph = 0; idx = 0; sub = 0; dn = 0; cyc = 0; t0 = 0;
    pend_m = 0; en_m = 0; rdy_m = 0;
    init_refs = 0; run_refs = 0; hold_refs = 0; exp_run_refs = 0; holdoff_bursts = 0;
  endtask

  task automatic model_step();
    int c1;
    bit start;
    c1 = cyc + 1;
    start = 0;
    case (ph)
      0: begin
        idx++;
        if (idx == q.size()) begin
          ph = 1; sub = 0; dn = 0; en_m = 1; t0 = c1;
        end
      end
      1: begin
        if (sub == DC - 1) begin
          dn++;
          sub = 0;
          if (dn == DCNT) rdy_m = 1;
          if (pend_m != 0) begin
            ph = 3; start = 1;
            if (dn < DCNT) holdoff_bursts++;
          end else if (dn == DCNT) ph = 2;
        end else sub++;
      end
      2: if (pend_m != 0) begin ph = 3; sub = 0; start = 1; end
      default: begin
        if (sub == GRP * S - 1) begin
          sub = 0;
          ph = (dn < DCNT) ? 1 : 2;
        end else sub++;
      end
    endcase
    if (en_m != 0 && c1 > t0 && ((c1 - t0) % tper) == 0) pend_m = 1;
    else if (start) pend_m = 0;
    cyc = c1;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ec;
      string tag;
      ec = exp_cmd();
      if (ph == 0) tag = (idx < P) ? "R1" : "R2";
      else if (ph == 1) tag = "R4";
      else if (ph == 3 && dn < DCNT) tag = "R8";
      else tag = "R7";
      chk(cmd == ec[1:0], tag, "cmd", cmd, ec);
      chk(mode_addr == ((ec == 3) ? 13'h088 : 13'h000), "R3", "mode_addr", mode_addr,
          (ec == 3) ? 'h88 : 0);
      chk(dummy_busy == (ph == 1), "R4", "dummy_busy", dummy_busy, (ph == 1));
      chk(ready == (rdy_m != 0), "R5", "ready", ready, rdy_m);
      chk(refresh_slow == (size_mb <= SMALL), "R9", "refresh_slow", refresh_slow, (size_mb <= SMALL));
      if (cmd == 2'b10) begin
        if (ph == 0) init_refs++;
        else begin
          run_refs++;
          if (ph == 3 && dn < DCNT) hold_refs++;
        end
      end
      if (ph != 0 && ec == 2) exp_run_refs++;
    end
  end

  task automatic run_one(input int sz, input int ncyc, input bit expect_hold);
    @(posedge clk);
    #1 rst_n = 1'b0;
    size_mb = 16'(sz);
    repeat (2) @(negedge clk);
    chk(cmd == 2'b00, "R1", "cmd in reset", cmd, 0);
    chk(ready == 1'b0, "R1", "ready in reset", ready, 0);
    chk(dummy_busy == 1'b0, "R1", "dummy_busy in reset", dummy_busy, 0);
    chk(refresh_slow == (sz <= SMALL), "R9", "rate select", refresh_slow, (sz <= SMALL));
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (ncyc) @(negedge clk);
    chk(init_refs == LOOPS * GRP, "R2", "init refresh count", init_refs, LOOPS * GRP);
    chk(ready == 1'b1, "R5", "ready at end of run", ready, 1);
    chk(run_refs == exp_run_refs, "R7", "periodic refresh count", run_refs, exp_run_refs);
    chk(run_refs >= GRP, "R7", "at least one periodic burst", run_refs, GRP);
    chk(run_refs % GRP == 0 || ph == 3, "R7", "refreshes come in groups", run_refs % GRP, 0);
    if (expect_hold) begin
      chk(holdoff_bursts > 0, "R8", "held-off burst seen", holdoff_bursts, 1);
      chk(hold_refs == GRP * holdoff_bursts, "R8", "refreshes between dummies", hold_refs,
          GRP * holdoff_bursts);
    end else begin
      chk(holdoff_bursts == 0, "R8", "no burst between dummies", holdoff_bursts, 0);
      chk(hold_refs == 0, "R6", "no refresh while dummies remain", hold_refs, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    run_one(64, 400, 1'b1);
    run_one(32, 400, 1'b0);
    run_one(33, 400, 1'b1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule